// File: doc/BRIEF.md
# Trap Routing and Vector Generator

This block sits at the trap entry point of a processor core. When a trap is taken it reads the current trap level, the processor-state and hyper-state words, the trap type, and a three-bit destination map for that trap type. From these it decides where the trap goes. There are four outcomes: reset-error handling, an error halt, a hyperprivileged handler or a privileged handler. It then forms the 64-bit handler address and the two sequential addresses after it.

It also makes the power-on reset entry. This is the power-on vector plus the initial trap level, global level, processor-state word, hyper-state word and tick value. Sampling happens on a clock edge. The results appear on registered outputs one cycle later, with a one-cycle valid pulse. The core saves the architectural state and fetches the handler; this block does neither.

Top module: `trap_vector_unit`

## Requirements
- R1: The current privilege is user when processor-state bit 2 is 0. When that bit is 1, the privilege is privileged if hyper-state bit 2 is 0 and hyperprivileged if it is 1. The destination is destMap bit 0 for user, bit 1 for privileged and bit 2 for hyperprivileged, where 1 means hyperprivileged and 0 means privileged.
- R2: When hyper-state bit 5 is 1, or the trap level equals MAX_TL-1, the route is reset-error (outRoute=2). The reported type is 5 and the PC is 0xFFF0000000 OR ((type<<5) AND 0xFF). This check takes precedence over all others.
- R3: Otherwise, a trap level equal to or above MAX_TL gives the error-halt route (outRoute=3). The reported type is the trap type, and all three addresses are zero.
- R4: Otherwise, a trap level above MAX_PTL with a privileged destination is redirected to the hyperprivileged route (outRoute=1) with type 2.
- R5: The hyperprivileged vector is the hyper base with its low 14 bits cleared, OR (type<<5) in bits 13:5.
- R6: The privileged route (outRoute=0) gives the privileged base with its low 15 bits cleared, OR bit 14 when the trap level is 1 or more (that is, the new level exceeds 1), OR (type<<5) in bits 13:5.
- R7: For every non-halt route, the next address is PC+4 and the one after it is PC+8.
- R8: A power-on request gives the reset-error route with type 1 and PC 0xFFF0000020. It sets the trap level to MAX_TL, the global level to MAX_GL, and the processor-state word to 0x10 (bit 4 only). The hyper-state becomes the input word with bits 5 and 2 set and bits 10 and 0 cleared. The tick value is bit 63 only.
- R9: Outputs update one clock after a request is sampled, and outValid pulses for exactly that cycle. Without a request the outputs hold their values.
- R10: When a power-on request and a trap request are sampled together, the power-on request wins.
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request strobe |
| porReq | input | 1 | Power-on entry request strobe |
| trapType | input | 9 | Pending trap type |
| trapLevel | input | TL_W (3) | Current trap level |
| procState | input | PS_W (13) | Processor-state word |
| hyperState | input | HS_W (11) | Hyper-state word |
| destMap | input | 3 | Per-privilege destination, 1 = hyperprivileged |
| privBase | input | 64 | Privileged trap base address |
| hyperBase | input | 64 | Hyperprivileged trap base address |
| outValid | output | 1 | Result valid pulse |
| outRoute | output | 2 | 0 priv, 1 hyper, 2 reset-error, 3 halt |
| outType | output | 9 | Type used for the vector |
| outPc | output | 64 | Handler PC |
| outNpc | output | 64 | Handler PC + 4 |
| outNnpc | output | 64 | Handler PC + 8 |
| porValid | output | 1 | Power-on values valid pulse |
| porTrapLevel | output | TL_W (3) | Power-on trap level |
| porGlobalLevel | output | GL_W (2) | Power-on global level |
| porProcState | output | PS_W (13) | Power-on processor-state word |
| porHyperState | output | HS_W (11) | Power-on hyper-state word |
| porTick | output | 64 | Power-on tick value |

## Verification
The hardest cases to reach are the ones where route rules overlap. Examples are a trap level that is both above MAX_PTL and equal to MAX_TL-1, and a reset-error flag set while the level is already at the halt level. The expected results there depend on the precedence order. The bench sweeps every trap level including the one above MAX_TL, both values of the reset-error flag, all three privileges and all eight destination maps, for several trap types. Every overlap is therefore hit and checked against an arithmetic model.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

  localparam int TYPE_W = 9;

  typedef enum logic [1:0] {
    RT_PRIV  = 2'd0,
    RT_HYPER = 2'd1,
    RT_RED   = 2'd2,
    RT_HALT  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    LV_USER  = 2'd0,
    LV_PRIV  = 2'd1,
    LV_HYPER = 2'd2
  } priv_e;

  localparam logic [TYPE_W-1:0] RED_TYPE  = 9'd5;
  localparam logic [TYPE_W-1:0] WDOG_TYPE = 9'd2;
  localparam logic [TYPE_W-1:0] POR_TYPE  = 9'd1;
  localparam logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000;

  localparam int PS_PRIV_BIT = 2;
  localparam int PS_FPEN_BIT = 4;
  localparam int HS_TLZ_BIT  = 0;
  localparam int HS_PRIV_BIT = 2;
  localparam int HS_RED_BIT  = 5;
  localparam int HS_IBE_BIT  = 10;

  typedef struct packed {
    logic              loadVec;
    logic              loadPor;
    route_e            route;
    logic [TYPE_W-1:0] vecType;
    logic              deepLevel;
  } strobe_t;

endpackage

// File: rtl/trap_route_ctrl.sv
module trap_route_ctrl
  import trapvec_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = 3,
  parameter int PS_W    = 13,
  parameter int HS_W    = 11
) (
  input  logic              trapReq,
  input  logic              porReq,
  input  logic [TYPE_W-1:0] trapType,
  input  logic [TL_W-1:0]   trapLevel,
  input  logic [PS_W-1:0]   procState,
  input  logic [HS_W-1:0]   hyperState,
  input  logic [2:0]        destMap,
  output strobe_t           strobe
);

  priv_e curLevel;
  logic  destHyper;
  int    levelNum;

  always_comb begin
    if (!procState[PS_PRIV_BIT])      curLevel = LV_USER;
    else if (!hyperState[HS_PRIV_BIT]) curLevel = LV_PRIV;
    else                               curLevel = LV_HYPER;
  end

  always_comb begin
    case (curLevel)
      LV_USER: destHyper = destMap[0];
      LV_PRIV: destHyper = destMap[1];
      default: destHyper = destMap[2];
    endcase
  end

  assign levelNum = int'(trapLevel);

  always_comb begin
    strobe = '0;
    if (porReq) begin
      strobe.loadVec = 1'b1;
      strobe.loadPor = 1'b1;
      strobe.route   = RT_RED;
      strobe.vecType = POR_TYPE;
    end else if (trapReq) begin
      strobe.loadVec = 1'b1;
      if (hyperState[HS_RED_BIT] || levelNum == MAX_TL - 1) begin
        strobe.route   = RT_RED;
        strobe.vecType = RED_TYPE;
      end else if (levelNum >= MAX_TL) begin
        strobe.route   = RT_HALT;
        strobe.vecType = trapType;
      end else if (levelNum > MAX_PTL && !destHyper) begin
        strobe.route   = RT_HYPER;
        strobe.vecType = WDOG_TYPE;
      end else if (destHyper) begin
        strobe.route   = RT_HYPER;
        strobe.vecType = trapType;
      end else begin
        strobe.route     = RT_PRIV;
        strobe.vecType   = trapType;
        strobe.deepLevel = (levelNum >= 1);
      end
    end
  end

endmodule

// File: rtl/trap_vec_dp.sv
module trap_vec_dp
  import trapvec_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int TL_W   = 3,
  parameter int GL_W   = 2,
  parameter int PS_W   = 13,
  parameter int HS_W   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [63:0]       privBase,
  input  logic [63:0]       hyperBase,
  input  logic [HS_W-1:0]   hyperState,
  output logic              outValid,
  output route_e            outRoute,
  output logic [TYPE_W-1:0] outType,
  output logic [63:0]       outPc,
  output logic [63:0]       outNpc,
  output logic [63:0]       outNnpc,
  output logic              porValid,
  output logic [TL_W-1:0]   porTrapLevel,
  output logic [GL_W-1:0]   porGlobalLevel,
  output logic [PS_W-1:0]   porProcState,
  output logic [HS_W-1:0]   porHyperState,
  output logic [63:0]       porTick
);

  logic [63:0]     pcNext, npcNext, nnpcNext;
  logic [HS_W-1:0] hsPor;

  always_comb begin
    case (strobe.route)
      RT_RED:   pcNext = RED_BASE | {56'd0, strobe.vecType[2:0], 5'd0};
      RT_HYPER: pcNext = {hyperBase[63:14], strobe.vecType, 5'd0};
      RT_PRIV:  pcNext = {privBase[63:15], strobe.deepLevel, strobe.vecType, 5'd0};
      default:  pcNext = 64'd0;
    endcase
    if (strobe.route == RT_HALT) begin
      npcNext  = 64'd0;
      nnpcNext = 64'd0;
    end else begin
      npcNext  = pcNext + 64'd4;
      nnpcNext = pcNext + 64'd8;
    end
  end

  always_comb begin
    hsPor = hyperState;
    hsPor[HS_RED_BIT]  = 1'b1;
    hsPor[HS_PRIV_BIT] = 1'b1;
    hsPor[HS_IBE_BIT]  = 1'b0;
    hsPor[HS_TLZ_BIT]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      outRoute       <= RT_PRIV;
      outType        <= '0;
      outPc          <= '0;
      outNpc         <= '0;
      outNnpc        <= '0;
      porValid       <= 1'b0;
      porTrapLevel   <= '0;
      porGlobalLevel <= '0;
      porProcState   <= '0;
      porHyperState  <= '0;
      porTick        <= '0;
    end else begin
      outValid <= strobe.loadVec;
      porValid <= strobe.loadPor;
      if (strobe.loadVec) begin
        outRoute <= strobe.route;
        outType  <= strobe.vecType;
        outPc    <= pcNext;
        outNpc   <= npcNext;
        outNnpc  <= nnpcNext;
      end
      if (strobe.loadPor) begin
        porTrapLevel   <= TL_W'(MAX_TL);
        porGlobalLevel <= GL_W'(MAX_GL);
        porProcState   <= PS_W'(1) << PS_FPEN_BIT;
        porHyperState  <= hsPor;
        porTick        <= 64'h8000_0000_0000_0000;
      end
    end
  end

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trapvec_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int PS_W    = 13,
  parameter int HS_W    = 11,
  localparam int TL_W   = $clog2(MAX_TL + 2),
  localparam int GL_W   = $clog2(MAX_GL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic              porReq,
  input  logic [TYPE_W-1:0] trapType,
  input  logic [TL_W-1:0]   trapLevel,
  input  logic [PS_W-1:0]   procState,
  input  logic [HS_W-1:0]   hyperState,
  input  logic [2:0]        destMap,
  input  logic [63:0]       privBase,
  input  logic [63:0]       hyperBase,
  output logic              outValid,
  output logic [1:0]        outRoute,
  output logic [TYPE_W-1:0] outType,
  output logic [63:0]       outPc,
  output logic [63:0]       outNpc,
  output logic [63:0]       outNnpc,
  output logic              porValid,
  output logic [TL_W-1:0]   porTrapLevel,
  output logic [GL_W-1:0]   porGlobalLevel,
  output logic [PS_W-1:0]   porProcState,
  output logic [HS_W-1:0]   porHyperState,
  output logic [63:0]       porTick
);

  strobe_t strobe;
  route_e  routeReg;

  trap_route_ctrl #(
    .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .PS_W(PS_W), .HS_W(HS_W)
  ) u_ctrl (
    .trapReq(trapReq), .porReq(porReq), .trapType(trapType),
    .trapLevel(trapLevel), .procState(procState), .hyperState(hyperState),
    .destMap(destMap), .strobe(strobe)
  );

  trap_vec_dp #(
    .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .TL_W(TL_W), .GL_W(GL_W),
    .PS_W(PS_W), .HS_W(HS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .privBase(privBase),
    .hyperBase(hyperBase), .hyperState(hyperState),
    .outValid(outValid), .outRoute(routeReg), .outType(outType),
    .outPc(outPc), .outNpc(outNpc), .outNnpc(outNnpc),
    .porValid(porValid), .porTrapLevel(porTrapLevel),
    .porGlobalLevel(porGlobalLevel), .porProcState(porProcState),
    .porHyperState(porHyperState), .porTick(porTick)
  );

  assign outRoute = routeReg;

endmodule

// File: rtl/trapvec_chk.sv
module trapvec_chk #(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = 3,
  parameter int PS_W    = 13,
  parameter int HS_W    = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapReq,
  input logic            porReq,
  input logic [TL_W-1:0] trapLevel,
  input logic [PS_W-1:0] procState,
  input logic [HS_W-1:0] hyperState,
  input logic [2:0]      destMap,
  input logic            outValid,
  input logic [1:0]      outRoute,
  input logic [8:0]      outType,
  input logic [63:0]     outPc,
  input logic [63:0]     outNpc,
  input logic [63:0]     outNnpc,
  input logic            porValid,
  input logic [PS_W-1:0] porProcState
);

  logic destSel;
  assign destSel = !procState[2] ? destMap[0] : (!hyperState[2] ? destMap[1] : destMap[2]);

  // R9
  req_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq || porReq) |=> outValid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq || porReq) |=> (!outValid && $stable(outPc) && $stable(outRoute)));

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRoute != 2'd3) |-> (outNnpc - outNpc == 64'd4));

  // R3
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRoute == 2'd3) |-> (outPc == 64'd0 && outNnpc == 64'd0));

  // R2
  red_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRoute == 2'd2) |-> (outPc[63:8] == 56'h0000_00FF_F000_00));

  // R10
  por_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> (porValid && outRoute == 2'd2 && outType == 9'd1));

  // R8
  por_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    porValid |-> (porProcState == PS_W'(16)));

  // R4
  wdog_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !porReq && !hyperState[5] && int'(trapLevel) > MAX_PTL &&
     int'(trapLevel) < MAX_TL - 1 && !destSel)
    |=> (outRoute == 2'd1 && outType == 9'd2));

endmodule

bind trap_vector_unit trapvec_chk #(
  .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .PS_W(PS_W), .HS_W(HS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .porReq(porReq),
  .trapLevel(trapLevel), .procState(procState), .hyperState(hyperState),
  .destMap(destMap), .outValid(outValid), .outRoute(outRoute),
  .outType(outType), .outPc(outPc), .outNpc(outNpc), .outNnpc(outNnpc),
  .porValid(porValid), .porProcState(porProcState)
);

// File: tb/sim_trap_vector_unit.sv
module sim_trap_vector_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic        porReq = 1'b0;
  logic [8:0]  trapType = '0;
  logic [2:0]  trapLevel = '0;
  logic [12:0] procState = '0;
  logic [10:0] hyperState = '0;
  logic [2:0]  destMap = '0;
  logic [63:0] privBase = '0;
  logic [63:0] hyperBase = '0;
  logic        outValid;
  logic [1:0]  outRoute;
  logic [8:0]  outType;
  logic [63:0] outPc, outNpc, outNnpc;
  logic        porValid;
  logic [2:0]  porTrapLevel;
  logic [1:0]  porGlobalLevel;
  logic [12:0] porProcState;
  logic [10:0] porHyperState;
  logic [63:0] porTick;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  trap_vector_unit u0 (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .porReq(porReq),
    .trapType(trapType), .trapLevel(trapLevel), .procState(procState),
    .hyperState(hyperState), .destMap(destMap), .privBase(privBase),
    .hyperBase(hyperBase), .outValid(outValid), .outRoute(outRoute),
    .outType(outType), .outPc(outPc), .outNpc(outNpc), .outNnpc(outNnpc),
    .porValid(porValid), .porTrapLevel(porTrapLevel),
    .porGlobalLevel(porGlobalLevel), .porProcState(porProcState),
    .porHyperState(porHyperState), .porTick(porTick)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [8:0]  typeList [6];
    logic [63:0] pbList [2];
    logic [63:0] hbList [2];
    typeList[0] = 9'h000; typeList[1] = 9'h011; typeList[2] = 9'h028;
    typeList[3] = 9'h07F; typeList[4] = 9'h100; typeList[5] = 9'h1FF;
    pbList[0] = 64'hDEAD_BEEF_CAFE_F00D; pbList[1] = 64'h0000_0000_0001_7FFF;
    hbList[0] = 64'h1234_5678_9ABC_DEF7; hbList[1] = 64'hFFFF_FFFF_FFFF_C001;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 outValid", {63'd0, outValid}, 64'd0);
    chk("R11 outPc", outPc, 64'd0);
    chk("R11 porTick", porTick, 64'd0);
    chk("R11 porValid", {63'd0, porValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 and R10: power-on request together with a trap request
    hyperState = 11'b101_1100_0011;
    trapReq = 1'b1; porReq = 1'b1; trapLevel = 3'd0; trapType = 9'h28;
    @(negedge clk);
    trapReq = 1'b0; porReq = 1'b0;
    chk("R10 route", {62'd0, outRoute}, 64'd2);
    chk("R10 type", {55'd0, outType}, 64'd1);
    chk("R8 pc", outPc, 64'h0000_00FF_F000_0020);
    chk("R8 npc", outNpc, 64'h0000_00FF_F000_0024);
    chk("R8 nnpc", outNnpc, 64'h0000_00FF_F000_0028);
    chk("R8 tl", {61'd0, porTrapLevel}, 64'd6);
    chk("R8 gl", {62'd0, porGlobalLevel}, 64'd3);
    chk("R8 pstate", {51'd0, porProcState}, 64'h10);
    chk("R8 hstate", {53'd0, porHyperState}, {53'd0, (11'b101_1100_0011 | 11'h024) & ~11'h401});
    chk("R8 tick", porTick, 64'h8000_0000_0000_0000);
    chk("R9 porValid", {63'd0, porValid}, 64'd1);
    @(negedge clk);
    chk("R9 pulse", {63'd0, porValid}, 64'd0);

    // Sweep: R1 to R7, R9
    for (int bi = 0; bi < 2; bi++) begin
      for (int tl = 0; tl < 8; tl++) begin
        for (int rf = 0; rf < 2; rf++) begin
          for (int lv = 0; lv < 3; lv++) begin
            for (int dm = 0; dm < 8; dm++) begin
              for (int ti = 0; ti < 6; ti++) begin
                logic [12:0] ps;
                logic [10:0] hs;
                logic        dH;
                logic [1:0]  eRoute;
                logic [8:0]  eType;
                logic [63:0] ePc, eNpc, eNnpc, prevPc;
                string       tg;
                ps = 13'h1A5B;
                hs = 11'h2C3 ^ 11'(ti * 11'h111);
                ps[2] = (lv != 0);
                hs[2] = (lv == 2) ? 1'b1 : ((lv == 1) ? 1'b0 : hs[2]);
                hs[5] = rf[0];
                dH = dm[lv];
                if (rf != 0 || tl == 5) begin
                  eRoute = 2'd2; eType = 9'd5; tg = "R2";
                  ePc = 64'h0000_00FF_F000_00A0;
                end else if (tl >= 6) begin
                  eRoute = 2'd3; eType = typeList[ti]; tg = "R3";
                  ePc = 64'd0;
                end else if (tl > 2 && !dH) begin
                  eRoute = 2'd1; eType = 9'd2; tg = "R4";
                  ePc = {hbList[bi][63:14], 14'd0} | 64'(9'd2) << 5;
                end else if (dH) begin
                  eRoute = 2'd1; eType = typeList[ti]; tg = "R5";
                  ePc = {hbList[bi][63:14], 14'd0} | (64'(typeList[ti]) << 5);
                end else begin
                  eRoute = 2'd0; eType = typeList[ti]; tg = "R6";
                  ePc = {pbList[bi][63:15], 15'd0} | (tl >= 1 ? 64'h4000 : 64'd0)
                        | (64'(typeList[ti]) << 5);
                end
                eNpc  = (eRoute == 2'd3) ? 64'd0 : ePc + 64'd4;
                eNnpc = (eRoute == 2'd3) ? 64'd0 : ePc + 64'd8;

                procState = ps; hyperState = hs; destMap = 3'(dm);
                trapLevel = 3'(tl); trapType = typeList[ti];
                privBase = pbList[bi]; hyperBase = hbList[bi];
                trapReq = 1'b1;
                @(negedge clk);
                trapReq = 1'b0;
                chk({tg, (tg == "R5" || tg == "R6") ? " R1 route" : " route"},
                    {62'd0, outRoute}, {62'd0, eRoute});
                chk({tg, " type"}, {55'd0, outType}, {55'd0, eType});
                chk({tg, " pc"}, outPc, ePc);
                chk("R7 npc", outNpc, eNpc);
                chk("R7 nnpc", outNnpc, eNnpc);
                chk("R9 valid", {63'd0, outValid}, 64'd1);
                prevPc = outPc;
                if (ti == 0 && dm == 0) begin
                  // R9: no request, outputs hold while other inputs move
                  privBase = ~privBase; hyperBase = ~hyperBase; trapLevel = ~trapLevel;
                  @(negedge clk);
                  chk("R9 hold valid", {63'd0, outValid}, 64'd0);
                  chk("R9 hold pc", outPc, prevPc);
                end
              end
            end
          end
        end
      end
    end

    // R11: reset clears after activity
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 outPc after reset", outPc, 64'd0);
    chk("R11 porProcState after reset", {51'd0, porProcState}, 64'd0);
    finishRun();
  end

endmodule